// File: doc/BRIEF.md
# Two-Cycle Width-Adapting DMA Transfer Engine

This block carries out one DMA transfer unit, a byte or a halfword, as two separate phases on a simple request/ready bus. In the read phase it drives the source address and collects the data into an internal holding register. In the write phase it drives the destination address and sends the held data out. The two phases are always separated by exactly one idle clock.

The source and the destination each report their bus width: 8, 16 or 32 bits. A halfword coming from an 8-bit source is gathered with two byte reads. A halfword going to an 8-bit destination is scattered with two byte writes. On every split or merged access the low byte moves first, at the base address, and the high byte second, at base + 1. A 32-bit port is read with a 16-bit access whose upper half is ignored. In a typical system, peripheral registers sit on a 16-bit port, internal RAM on a 32-bit port and external memory on an 8- or 16-bit port.

A channel arbiter owns the block. It raises `start_i` with the addresses, size and widths, and waits for `done_o`. Channel priority and address stepping between units are handled outside this block.

Top module: `dma_xfer_engine`

## Requirements
- R1: While idle, a one-clock `start_i` captures the request, and on the next clock a read cycle (`bus_req_o`=1, `bus_we_o`=0) drives the source address. A `start_i` seen while `busy_o` is high is ignored and starts no extra bus cycle.
- R2: Exactly one clock with `bus_req_o` low separates the acceptance of the last read from the first write cycle.
- R3: A halfword from a source of width code 1, 2 or 3 (16, 32, 32 bits) to a destination of width code 0 (8 bits) uses one 16-bit read at the source, then an 8-bit write of the low byte at the destination and an 8-bit write of the high byte at destination + 1.
- R4: A halfword from a width-0 source to a destination of width code 1, 2 or 3 uses an 8-bit read at the source (low byte), an 8-bit read at source + 1 (high byte), then one 16-bit write of {high, low} at the destination.
- R5: A halfword between two ports that are both 16 or 32 bits wide uses one 16-bit read and one 16-bit write. Read data bits above bit 15 have no effect on the written value.
- R6: A byte transfer (`size_i`=0) uses one 8-bit read and one 8-bit write, whatever the widths. Only `bus_rdata_i[7:0]` is used.
- R7: While `bus_req_o` is high and `bus_ready_i` is low, the cycle holds: `bus_req_o`, address, `bus_we_o` and `bus_be_o` stay unchanged until ready is seen.
- R8: `done_o` is high for exactly one clock, in the clock after the last write is accepted. `busy_o` is low on the following clock.
- R9: After reset, `bus_req_o`, `bus_we_o`, `done_o`, `busy_o` and `bus_be_o` are all zero.
- R10: Data is right-aligned on the bus. An 8-bit access uses strobes 0001 and `bus_wdata_o[7:0]`; a 16-bit access uses strobes 0011 and `bus_wdata_o[15:0]`. Unused write-data bits are zero, and strobes are zero when no cycle is requested.
- R11: A halfword from a width-0 source to a width-0 destination uses two byte reads (source, source + 1) and then two byte writes (destination, destination + 1), low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one transfer unit (accepted when idle) |
| src_addr_i | input | AW | Source base address |
| dst_addr_i | input | AW | Destination base address |
| size_i | input | 1 | 0 = byte, 1 = halfword |
| src_width_i | input | 2 | Source bus width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| dst_width_i | input | 2 | Destination bus width, same coding |
| bus_rdata_i | input | DW | Read data, right-aligned |
| bus_ready_i | input | 1 | Current bus cycle completes on this clock |
| bus_req_o | output | 1 | Bus cycle requested |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | AW | Cycle address |
| bus_wdata_o | output | DW | Write data, right-aligned |
| bus_be_o | output | DW/8 | Byte strobes of the current cycle |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-clock pulse after the final write |

## Verification
The assertions check on every clock the properties that do not depend on data:
- the read that follows an accepted start,
- the single idle clock between the phases,
- the frozen cycle during wait states,
- the shape of the done pulse,
- the legal strobe patterns.

Only the bench scenarios can show that each width pairing produces the right number and order of beats, with the right addresses. They also show that the bytes land in the right lanes, that garbage in the upper read lanes never reaches the written data, and that a start issued mid-transfer produces no extra cycles.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam logic [1:0] BW8 = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_GAP,
    ST_WRITE,
    ST_DONE
  } xfer_state_e;

  // rd_two/wr_two: phase is split into two byte beats
  // rd_wide/wr_wide: phase uses one 16-bit access
  typedef struct packed {
    logic rd_two;
    logic wr_two;
    logic rd_wide;
    logic wr_wide;
  } beat_plan_t;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dma_beat_plan.sv
module dma_beat_plan
  import dma_xfer_pkg::*;
(
  input  logic       half_i,
  input  logic [1:0] src_w_i,
  input  logic [1:0] dst_w_i,
  output beat_plan_t plan_o
);
  logic src_narrow, dst_narrow;

  always_comb begin
    src_narrow     = (src_w_i == BW8);
    dst_narrow     = (dst_w_i == BW8);
    plan_o.rd_two  = half_i && src_narrow;
    plan_o.wr_two  = half_i && dst_narrow;
    plan_o.rd_wide = half_i && !src_narrow;
    plan_o.wr_wide = half_i && !dst_narrow;
  end
endmodule

// File: rtl/dma_hold_reg.sv
module dma_hold_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          cap_wide_i,
  input  logic          cap_hi_i,
  input  logic [15:0]   rdata_i,
  input  logic          out_en_i,
  input  logic          out_wide_i,
  input  logic          sel_hi_i,
  output logic [DW-1:0] wdata_o
);
  logic [15:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (cap_i) begin
      if (cap_wide_i)    hold_d = rdata_i;
      else if (cap_hi_i) hold_d[15:8] = rdata_i[7:0];
      else               hold_d[7:0]  = rdata_i[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (cap_i) hold_q <= hold_d;
  end

  always_comb begin
    wdata_o = '0;
    if (out_en_i) begin
      if (out_wide_i)    wdata_o[15:0] = hold_q;
      else if (sel_hi_i) wdata_o[7:0]  = hold_q[15:8];
      else               wdata_o[7:0]  = hold_q[7:0];
    end
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic        ready_i,
  input  beat_plan_t  plan_i,
  output xfer_state_e state_o,
  output logic        beat_o,
  output logic        req_o,
  output logic        we_o,
  output logic        cap_o,
  output logic        done_o,
  output logic        busy_o
);
  xfer_state_e state_q, state_d;
  logic        beat_q, beat_d;
  logic        rd_last, wr_last;

  assign rd_last = !plan_i.rd_two || beat_q;
  assign wr_last = !plan_i.wr_two || beat_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (accept_i) begin
        state_d = ST_READ;
        beat_d  = 1'b0;
      end
      ST_READ: if (ready_i) begin
        if (rd_last) begin
          state_d = ST_GAP;
          beat_d  = 1'b0;
        end else begin
          beat_d = 1'b1;
        end
      end
      ST_GAP: state_d = ST_WRITE;
      ST_WRITE: if (ready_i) begin
        if (wr_last) begin
          state_d = ST_DONE;
          beat_d  = 1'b0;
        end else begin
          beat_d = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign we_o    = (state_q == ST_WRITE);
  assign cap_o   = (state_q == ST_READ) && ready_i;
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);

  // R2: one idle clock between the final read and the first write
  p_one_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && ready_i && rd_last) |=> (!req_o ##1 (req_o && we_o)));

  // R8: done follows the final write, then the block goes idle
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && ready_i && wr_last) |=> (done_o ##1 !busy_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   src_addr_i,
  input  logic [AW-1:0]   dst_addr_i,
  input  logic            size_i,
  input  logic [1:0]      src_width_i,
  input  logic [1:0]      dst_width_i,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_ready_i,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  output logic [DW/8-1:0] bus_be_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int NBE = DW / 8;

  logic          rst_n_sync;
  logic          accept;
  logic [AW-1:0] src_q, dst_q;
  logic          half_q;
  logic [1:0]    src_w_q, dst_w_q;
  beat_plan_t    plan;
  xfer_state_e   state;
  logic          beat, cap, wide_now;
  logic          unused_rdata_hi;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      src_q   <= '0;
      dst_q   <= '0;
      half_q  <= 1'b0;
      src_w_q <= '0;
      dst_w_q <= '0;
    end else if (accept) begin
      src_q   <= src_addr_i;
      dst_q   <= dst_addr_i;
      half_q  <= size_i;
      src_w_q <= src_width_i;
      dst_w_q <= dst_width_i;
    end
  end

  dma_beat_plan u_plan (
    .half_i  (half_q),
    .src_w_i (src_w_q),
    .dst_w_i (dst_w_q),
    .plan_o  (plan)
  );

  dma_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .accept_i (accept),
    .ready_i  (bus_ready_i),
    .plan_i   (plan),
    .state_o  (state),
    .beat_o   (beat),
    .req_o    (bus_req_o),
    .we_o     (bus_we_o),
    .cap_o    (cap),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  dma_hold_reg #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cap_i      (cap),
    .cap_wide_i (plan.rd_wide),
    .cap_hi_i   (beat),
    .rdata_i    (bus_rdata_i[15:0]),
    .out_en_i   (state == ST_WRITE),
    .out_wide_i (plan.wr_wide),
    .sel_hi_i   (beat),
    .wdata_o    (bus_wdata_o)
  );

  assign unused_rdata_hi = ^bus_rdata_i[DW-1:16];

  assign wide_now   = bus_we_o ? plan.wr_wide : plan.rd_wide;
  assign bus_addr_o = (bus_we_o ? dst_q : src_q) + AW'(beat);

  always_comb begin
    bus_be_o = '0;
    if (bus_req_o) bus_be_o = {{(NBE-2){1'b0}}, wide_now, 1'b1};
  end

  // R1: accepted start leads to a read at the source address
  p_start_reads_src_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start_i && !busy_o) |=> (bus_req_o && !bus_we_o && bus_addr_o == $past(src_addr_i)));

  // R7: a cycle waiting for ready holds its request, address and control
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o)
                                     && $stable(bus_we_o) && $stable(bus_be_o)));

  // R10: only byte or halfword strobes on a live cycle
  p_lane_shape_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    bus_req_o |-> (bus_be_o == NBE'(1) || bus_be_o == NBE'(3)));
endmodule

// File: tb/sim_dma_xfer_engine.sv
module sim_dma_xfer_engine;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        last;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic          size_i = 1'b0;
  logic [1:0]    src_width_i = '0, dst_width_i = '0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic          bus_ready_i = 1'b0;
  logic          bus_req_o, bus_we_o, busy_o, done_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [3:0]    bus_be_o;

  item_t exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  int    wait_n = 0;
  int    done_seen = 0;
  int    cycles = 0;
  logic  expect_done = 1'b0;

  always #4 clk = ~clk;

  dma_xfer_engine #(.AW(AW), .DW(DW)) u0 (.*);

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h3C ^ {a[11:8], a[15:12]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor and bus responder
  int       wc = 0, gap_cnt = 0;
  bit       in_gap = 0;
  logic [31:0] hold_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (expect_done) begin
        chk(done_o === 1'b1, "R8", "done after last write", 32'(done_o), 1);
        expect_done = 1'b0;
        done_seen++;
      end else if (done_o) begin
        chk(0, "R8", "spurious done", 1, 0);
      end
      if (bus_ready_i) wc = 0;
      if (bus_req_o) begin
        if (in_gap && bus_we_o) begin
          chk(gap_cnt == 1, "R2", "idle clocks between phases", gap_cnt, 1);
          in_gap = 0;
        end
        if (wc == 0) hold_addr = bus_addr_o;
        else chk(bus_addr_o == hold_addr, "R7", "address held in wait", bus_addr_o, hold_addr);
        if (wc >= wait_n) begin
          bus_ready_i <= 1'b1;
          bus_rdata_i <= {16'hBEEF, mem_byte(bus_addr_o + 1), mem_byte(bus_addr_o)};
          if (exp_q.size() == 0) begin
            chk(0, "R1", "unexpected bus cycle", bus_addr_o, 0);
          end else begin
            item_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_we_o == e.we, t, "direction", 32'(bus_we_o), 32'(e.we));
            chk(bus_addr_o == e.addr, t, "address", bus_addr_o, e.addr);
            chk(bus_be_o == e.be, t, "strobes (R10)", 32'(bus_be_o), 32'(e.be));
            if (e.we) chk(bus_wdata_o == e.wdata, t, "write data (R10)", bus_wdata_o, e.wdata);
            if (e.we && e.last) expect_done = 1'b1;
          end
          if (!bus_we_o) begin
            in_gap = 1;
            gap_cnt = 0;
          end
        end else begin
          bus_ready_i <= 1'b0;
          wc++;
        end
      end else begin
        bus_ready_i <= 1'b0;
        wc = 0;
        if (in_gap) gap_cnt++;
      end
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic last, input string tag);
    item_t e;
    e.we = we; e.addr = a; e.wdata = d; e.be = be; e.last = last;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run_xfer(input logic [31:0] src, input logic [31:0] dst, input logic half,
                          input logic [1:0] sw, input logic [1:0] dw, input int waits,
                          input bit poke_busy, input string tag);
    logic [15:0] h;
    int d0;
    h = {mem_byte(src + 1), mem_byte(src)};
    if (!half) begin
      // R6: single byte each way
      push(0, src, 0, 4'b0001, 0, tag);
      push(1, dst, {24'h0, h[7:0]}, 4'b0001, 1, tag);
    end else begin
      if (sw == 2'd0) begin
        push(0, src, 0, 4'b0001, 0, tag);
        push(0, src + 1, 0, 4'b0001, 0, tag);
      end else begin
        push(0, src, 0, 4'b0011, 0, tag);
      end
      if (dw == 2'd0) begin
        push(1, dst, {24'h0, h[7:0]}, 4'b0001, 0, tag);
        push(1, dst + 1, {24'h0, h[15:8]}, 4'b0001, 1, tag);
      end else begin
        push(1, dst, {16'h0, h}, 4'b0011, 1, tag);
      end
    end
    wait_n = waits;
    d0 = done_seen;
    @(negedge clk);
    start_i = 1'b1; src_addr_i = src; dst_addr_i = dst;
    size_i = half; src_width_i = sw; dst_width_i = dw;
    @(negedge clk);
    start_i = 1'b0;
    chk(bus_req_o && !bus_we_o && bus_addr_o == src, "R1", "read at source after start",
        bus_addr_o, src);
    if (poke_busy) begin
      // R1: start while busy must be ignored
      start_i = 1'b1; src_addr_i = 32'h0000_7700; size_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 200 && done_seen == d0; i++) @(negedge clk);
    chk(done_seen > d0, tag, "transfer completed", done_seen, d0 + 1);
    chk(exp_q.size() == 0, tag, "all expected cycles seen", exp_q.size(), 0);
    @(negedge clk);
    chk(!busy_o, "R8", "idle after done", 32'(busy_o), 0);
    if (poke_busy) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!bus_req_o, "R1", "no cycle from ignored start", 32'(bus_req_o), 0);
      end
    end
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(!bus_req_o && !bus_we_o && !done_o && !busy_o && bus_be_o == 0, "R9", "reset outputs",
        {27'h0, bus_req_o, bus_we_o, done_o, busy_o, |bus_be_o}, 0);

    run_xfer(32'h0000_1000, 32'h0000_2000, 1'b0, 2'd1, 2'd0, 0, 0, "R6");
    run_xfer(32'h0000_1013, 32'h0000_2021, 1'b0, 2'd0, 2'd2, 1, 0, "R6");
    run_xfer(32'h0000_3400, 32'h0000_5600, 1'b1, 2'd1, 2'd0, 0, 0, "R3");
    run_xfer(32'h0000_3502, 32'h0000_5703, 1'b1, 2'd2, 2'd0, 2, 0, "R3");
    run_xfer(32'h0000_3606, 32'h0000_5808, 1'b1, 2'd3, 2'd0, 0, 0, "R3");
    run_xfer(32'h0000_4101, 32'h0000_6200, 1'b1, 2'd0, 2'd1, 0, 0, "R4");
    run_xfer(32'h0000_4203, 32'h0000_6304, 1'b1, 2'd0, 2'd2, 1, 0, "R4");
    run_xfer(32'h0000_8000, 32'h0000_9000, 1'b1, 2'd2, 2'd1, 0, 0, "R5");
    run_xfer(32'h0000_8102, 32'h0000_9104, 1'b1, 2'd1, 2'd2, 3, 0, "R5");
    run_xfer(32'h0000_8204, 32'h0000_9206, 1'b1, 2'd1, 2'd1, 0, 0, "R5");
    run_xfer(32'h0000_A0F0, 32'h0000_B0E0, 1'b1, 2'd0, 2'd0, 1, 0, "R11");
    run_xfer(32'h0000_C010, 32'h0000_D020, 1'b1, 2'd2, 2'd1, 2, 1, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule